// File: doc/BRIEF.md
# Activity-Based Standby Enable Controller

This block decides whether a group of high-speed channels is powered up (ACTIVE) or parked (STANDBY). It does this by watching a set of slow, active-low control lines, two by default. Each line is brought into the clock domain by a two-flop synchroniser. A per-line qualification filter then rejects pulses that are too short. A line counts as qualified LOW, or qualified HIGH, once its synchronised level has been stable for more than `SAMPLE` clock cycles. The filter's counter restarts whenever that line changes level.

Any qualified-LOW line is a wake request. Every line qualified HIGH at the same time is a sleep request. A sleep request does not drop the mode at once. It arms a pending phase that lasts `DELAY` cycles, and any wake request during that phase cancels it. Once in STANDBY the block stays there until a wake request appears. Wake-up happens within a fixed number of cycles of a line going low. After reset the block is ACTIVE with nothing pending.

Top module: `standby_enable_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `standby_o` is 0, `hs_en_o` is 1 and `sleep_pend_o` is 0.
- R2: A line of `ctl_n_i` held at 0 for `SAMPLE`+1 clock cycles or longer produces a wake request. Either line alone is enough, and the block is then ACTIVE (`standby_o`=0).
- R3: A 0 pulse of `SAMPLE` cycles or fewer on a line of `ctl_n_i` causes no wake request and leaves STANDBY unchanged.
- R4: `sleep_pend_o` rises `SAMPLE`+4 cycles after the last line of `ctl_n_i` goes to 1, provided every line is 1 from then on. While any line is held at 0, `sleep_pend_o` stays 0 and the block stays ACTIVE.
- R5: A wake request during the pending phase clears `sleep_pend_o` and returns the block to ACTIVE without entering STANDBY.
- R6: If no wake request occurs, `standby_o` rises exactly `DELAY` cycles after `sleep_pend_o` rises, and `sleep_pend_o` falls in the same cycle. A short 0 pulse (R3) during the pending phase does not cancel it.
- R7: In STANDBY the block stays in STANDBY until a wake request occurs, whatever the lines do without qualifying.
- R8: A line going to 0 and held there returns the block from STANDBY to ACTIVE `SAMPLE`+4 cycles later. This must be no more than the parameter `WAKE_LAT`, and `WAKE_LAT` < `SAMPLE`+4 is rejected at elaboration.
- R9: `hs_en_o` is always the inverse of `standby_o`. 1 enables the high-speed channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_n_i | input | NCH | Asynchronous active-low control lines; 0 requests activity |
| standby_o | output | 1 | 1 = STANDBY, 0 = ACTIVE |
| hs_en_o | output | 1 | High-speed channel enable, 1 in ACTIVE |
| sleep_pend_o | output | 1 | 1 while a sleep request waits out the enable delay |

## Verification
The hardest case to reach from the ports is a pending sleep phase that is interrupted in two different ways. In one, a qualified wake cancels it. In the other, an unqualified glitch must not cancel it. The stimulus reaches both by letting the lines qualify HIGH, checking `sleep_pend_o`, and then driving a line low either for long enough to qualify or for only four cycles. Afterwards it counts how many further cycles pass before STANDBY. The pulse-length boundary is also probed from STANDBY with low pulses of exactly `SAMPLE` and `SAMPLE`+1 cycles, and the enable delay is probed on the exact cycles `DELAY`-1 and `DELAY` after pending rises.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE  = 2'd0,
    MODE_PENDING = 2'd1,
    MODE_STANDBY = 2'd2
  } mode_t;
endpackage

// File: rtl/sbc_sync2.sv
module sbc_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      stab_q <= '1;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/sbc_qual_filter.sv
module sbc_qual_filter #(
  parameter int unsigned SAMPLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic q_low_o,
  output logic q_high_o
);
  localparam int unsigned CW = $clog2(SAMPLE + 1);
  localparam logic [CW-1:0] CMAX = CW'(SAMPLE);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          settled;

  assign settled = (cnt_q == CMAX);
  assign cnt_en  = (line_i != lvl_q) || !settled;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (line_i != lvl_q) begin
      lvl_d = line_i;
      cnt_d = '0;
    end else if (!settled) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_en) begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign q_low_o  = settled && !lvl_q;
  assign q_high_o = settled &&  lvl_q;

  // R3
  low_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_low_o) |-> $past(!line_i));

  // R3
  qual_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_low_o && q_high_o));
endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_pkg::*;
#(
  parameter int unsigned DELAY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req_i,
  input  logic sleep_req_i,
  output logic standby_o,
  output logic pend_o
);
  localparam int unsigned DW = $clog2(DELAY + 1);
  localparam logic [DW-1:0] DLAST = DW'(DELAY - 1);

  mode_t         st_q, st_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    unique case (st_q)
      MODE_ACTIVE: begin
        dcnt_d = '0;
        if (!wake_req_i && sleep_req_i) st_d = MODE_PENDING;
      end
      MODE_PENDING: begin
        if (wake_req_i) begin
          st_d   = MODE_ACTIVE;
          dcnt_d = '0;
        end else if (dcnt_q == DLAST) begin
          st_d   = MODE_STANDBY;
          dcnt_d = '0;
        end else begin
          dcnt_d = dcnt_q + 1'b1;
        end
      end
      MODE_STANDBY: begin
        dcnt_d = '0;
        if (wake_req_i) st_d = MODE_ACTIVE;
      end
      default: begin
        st_d   = MODE_ACTIVE;
        dcnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MODE_ACTIVE;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign standby_o = (st_q == MODE_STANDBY);
  assign pend_o    = (st_q == MODE_PENDING);

  // R2
  wake_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_i |=> (st_q == MODE_ACTIVE));

  // R6
  standby_via_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_o) |-> $past(pend_o));

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_o && !wake_req_i) |=> standby_o);

  // R4
  pend_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> $past(sleep_req_i && !wake_req_i));
endmodule

// File: rtl/standby_enable_ctrl.sv
module standby_enable_ctrl #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned SAMPLE   = 8,
  parameter int unsigned DELAY    = 20,
  parameter int unsigned WAKE_LAT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ctl_n_i,
  output logic           standby_o,
  output logic           hs_en_o,
  output logic           sleep_pend_o
);
  localparam int unsigned LW = $clog2(WAKE_LAT + 2);
  localparam logic [LW-1:0] LSAT  = LW'(WAKE_LAT);
  localparam logic [LW-1:0] LWORST = LW'(WAKE_LAT - 2);

  generate
    if (WAKE_LAT < SAMPLE + 4) begin : g_bad_lat
      $error("WAKE_LAT must be at least SAMPLE+4");
    end
    if (DELAY < 1) begin : g_bad_delay
      $error("DELAY must be at least 1");
    end
  endgenerate

  logic [NCH-1:0] line_s;
  logic [NCH-1:0] q_low, q_high;
  logic           wake_req, sleep_req;

  sbc_sync2 #(.WIDTH(NCH)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ctl_n_i),
    .sync_o  (line_s)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sbc_qual_filter #(.SAMPLE(SAMPLE)) i_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_s[c]),
      .q_low_o  (q_low[c]),
      .q_high_o (q_high[c])
    );
  end

  assign wake_req  = |q_low;
  assign sleep_req = &q_high;

  sbc_mode_fsm #(.DELAY(DELAY)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_req_i  (wake_req),
    .sleep_req_i (sleep_req),
    .standby_o   (standby_o),
    .pend_o      (sleep_pend_o)
  );

  assign hs_en_o = ~standby_o;

  // Wake-latency monitor: consecutive synchronised-low cycles per line.
  for (genvar c = 0; c < NCH; c++) begin : g_lat
    logic [LW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (line_s[c])      run_q <= '0;
      else if (run_q != LSAT)  run_q <= run_q + 1'b1;
    end

    // R8
    wake_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_o |-> (run_q <= LWORST));
  end

  // R9
  enable_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_o != standby_o);

  // R5
  pend_standby_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleep_pend_o && standby_o));
endmodule

// File: tb/test_standby_enable_ctrl.sv
module test_standby_enable_ctrl;
  localparam int NCH = 2;
  localparam int SAMPLE = 8;
  localparam int DELAY = 20;
  localparam int WAKE_LAT = 16;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] ctl_n;
  logic           standby, hs_en, pend;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  standby_enable_ctrl #(.NCH(NCH), .SAMPLE(SAMPLE), .DELAY(DELAY), .WAKE_LAT(WAKE_LAT))
    i_standby_enable_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_n_i(ctl_n),
      .standby_o(standby), .hs_en_o(hs_en), .sleep_pend_o(pend));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {ctl[1:0], hold[7:0], expected {standby, hs_en, pend}}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {2'b11, 8'd5,  3'b010},  // R1 no early sleep
    {2'b11, 8'd10, 3'b011},  // R4 pending
    {2'b11, 8'd20, 3'b100},  // R6 standby
    {2'b10, 8'd5,  3'b100},  // R3 short low ignored
    {2'b11, 8'd30, 3'b100},  // R7 held
    {2'b01, 8'd12, 3'b010},  // R8 wake on line 1 at SAMPLE+4
    {2'b11, 8'd14, 3'b011},  // R4 pending again
    {2'b10, 8'd12, 3'b010},  // R5 cancel by line 0
    {2'b11, 8'd16, 3'b011},  // R4
    {2'b11, 8'd20, 3'b100},  // R6
    {2'b00, 8'd30, 3'b010},  // R2 both low
    {2'b00, 8'd40, 3'b010},  // R2 stays active
    {2'b10, 8'd40, 3'b010},  // R4 one low blocks sleep
    {2'b11, 8'd14, 3'b011},  // R4
    {2'b01, 8'd4,  3'b011},  // R6 glitch keeps pending
    {2'b11, 8'd8,  3'b011},  // R6
    {2'b11, 8'd10, 3'b100}   // R6 standby after glitch
  };

  task automatic check(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {standby, hs_en, pend};
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: {standby,hs_en,pend} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] v, input int n);
    ctl_n = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    ctl_n = 2'b11;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(3'b010, "R1 in reset");
    rst_n = 1'b1;
    check(3'b010, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      hold(VEC[i][12:11], int'(VEC[i][10:3]));
      check(VEC[i][2:0], $sformatf("vector %0d", i));
    end

    // R6 exact delay: wake first, then let both lines qualify high
    hold(2'b00, 30);
    check(3'b010, "R2 setup");
    hold(2'b11, SAMPLE + 4);
    check(3'b011, "R4 pend at SAMPLE+4");
    hold(2'b11, DELAY - 1);
    check(3'b011, "R6 DELAY-1");
    hold(2'b11, 1);
    check(3'b100, "R6 at DELAY");

    // R3 boundary: SAMPLE-cycle low pulse is ignored
    hold(2'b10, SAMPLE);
    hold(2'b11, 20);
    check(3'b100, "R3 SAMPLE-cycle pulse");
    // R2 boundary: SAMPLE+1-cycle pulse wakes
    hold(2'b10, SAMPLE + 1);
    hold(2'b11, 4);
    check(3'b010, "R2 SAMPLE+1-cycle pulse");

    // R1 reset from pending
    hold(2'b11, SAMPLE + 6);
    check(3'b011, "R4 pending before reset");
    rst_n = 1'b0;
    @(negedge clk);
    check(3'b010, "R1 reset from pending");
    rst_n = 1'b1;
    hold(2'b11, 2);
    check(3'b010, "R1 no carry-over");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule